// File: doc/BRIEF.md
# OTP Byte Programming Sequencer

This block is the parallel programming and verify engine for a one-time-programmable code array of 4096 bytes. An external programmer drives a set of static control pins, a split address, a data byte and a program strobe. The block decodes the operating mode from those pins. On the rising end of a strobe pulse in a write mode, it captures the address and data. It then runs a self-timed byte write against a register model of the array. While that write runs it holds a ready output low.

In the read modes the block returns stored code bytes or fixed identification bytes one clock after the request. While a code write is in flight, a read of the address being written returns the byte with its most significant bit inverted. The programmer can poll on that bit, or on the ready output, to learn when the write is done. Three lock bits are written through the same timed path. They cannot be read back. Their only visible effect is to refuse later code writes and code verify reads.

All pins are plain, level-sampled signals on the system clock. There is no streaming interface and no back-pressure: a write request that arrives while the engine is busy is dropped, not queued.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, ready is 1, dout_en is 0 and dout is 0x00. Every array byte reads 0xFF and all three lock bits are unprogrammed.
- R2: A mode is active only while prog_mode=1 and store_en_n=0. Write modes also need vpp_hi=1 and are selected by ctl[3:0]: 1110 writes a code byte, 1111 writes lock bit 1, 0011 writes lock bit 2, 0101 writes lock bit 3. Read modes need vpp_hi=0 and strobe_n=1, and are selected by ctl: 1100 reads code, 0000 reads identification. Any other combination is idle.
- R3: A write request is the clock cycle in which strobe_n is first seen at 1 after having been 0, while a write mode is active. The address {addr_hi, addr_lo} and din are captured in that cycle.
- R4: ready falls on the clock after an accepted request and stays low for exactly WR_CYCLES clocks. The byte is committed to the array when ready returns high.
- R5: A write request that arrives while ready is low is ignored. It does not extend the current write, and its address and data are never stored.
- R6: While a code write is in flight, a code read of the address being written returns the captured byte with bit 7 inverted. Reads of any other address return the stored content.
- R7: A granted read drives dout and sets dout_en=1 on the clock after the request. In any non-read mode, dout_en=0 and dout=0x00 on the next clock.
- R8: An identification read returns 0x1E at address 0x030, 0x87 at 0x031 and 0x03 at 0x032, and 0x00 at any other address. It is granted whatever the lock state.
- R9: While lock bit 1 is programmed, a code write request is ignored: ready stays high.
- R10: A lock-bit write takes the same timed cycle as a code write. Once lock bit 1 or lock bit 2 is programmed, code reads are refused: dout_en=0 and dout=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears the array to 0xFF and the lock bits |
| prog_mode | input | 1 | Programming mode enable (high) |
| store_en_n | input | 1 | Must be low for any mode to be active |
| strobe_n | input | 1 | Program strobe, active-low pulse; its rising end requests a write |
| vpp_hi | input | 1 | Program-enable level present; chooses write modes over read modes |
| ctl | input | 4 | Mode select pattern |
| addr_lo | input | 8 | Low address byte |
| addr_hi | input | ADDR_W-8 | High address bits |
| din | input | 8 | Byte to be written |
| dout | output | 8 | Read data, registered |
| dout_en | output | 1 | High when dout carries a granted read |
| ready | output | 1 | Low while a timed write is in progress |

## Verification
A wrong timer count shows as ready rising a clock early or late, so the first write after reset exposes it. A bad commit shows up on the first verify read after ready rises. If the pending address or data register is corrupted, the polled bit 7 is wrong inside the busy window, or the wrong location changes. That location is caught the first time it is read back. A lock bit that is set wrongly or lost appears only through its effects: dout_en stays low on the next code read, or a code write fails to pull ready low. For this reason the bench reads the array both before and after each lock write.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_WR_CODE, OP_WR_LK1, OP_WR_LK2, OP_WR_LK3, OP_RD_CODE, OP_RD_SIG
  } otp_op_e;

  localparam logic [3:0] CTL_WR_CODE = 4'b1110;
  localparam logic [3:0] CTL_WR_LK1  = 4'b1111;
  localparam logic [3:0] CTL_WR_LK2  = 4'b0011;
  localparam logic [3:0] CTL_WR_LK3  = 4'b0101;
  localparam logic [3:0] CTL_RD_CODE = 4'b1100;
  localparam logic [3:0] CTL_RD_SIG  = 4'b0000;

  function automatic logic [7:0] sig_lookup(input logic [15:0] a);
    case (a)
      16'h0030: sig_lookup = 8'h1E;
      16'h0031: sig_lookup = 8'h87;
      16'h0032: sig_lookup = 8'h03;
      default:  sig_lookup = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
  import otp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_mode,
  input  logic       store_en_n,
  input  logic       strobe_n,
  input  logic       vpp_hi,
  input  logic [3:0] ctl,
  output otp_op_e    op,
  output logic       wr_req
);
  logic strobe_q;
  logic is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b1;
    else        strobe_q <= strobe_n;
  end

  always_comb begin
    op = OP_NONE;
    if (prog_mode && !store_en_n) begin
      if (vpp_hi) begin
        case (ctl)
          CTL_WR_CODE: op = OP_WR_CODE;
          CTL_WR_LK1:  op = OP_WR_LK1;
          CTL_WR_LK2:  op = OP_WR_LK2;
          CTL_WR_LK3:  op = OP_WR_LK3;
          default:     op = OP_NONE;
        endcase
      end else if (strobe_n) begin
        case (ctl)
          CTL_RD_CODE: op = OP_RD_CODE;
          CTL_RD_SIG:  op = OP_RD_SIG;
          default:     op = OP_NONE;
        endcase
      end
    end
  end

  assign is_write = (op == OP_WR_CODE) || (op == OP_WR_LK1) ||
                    (op == OP_WR_LK2) || (op == OP_WR_LK3);
  assign wr_req   = is_write && strobe_n && !strobe_q;

  // R3
  one_req_per_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req);
endmodule

// File: rtl/otp_write_timer.sv
module otp_write_timer #(
  parameter int CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(CYCLES - 1);
    end
  end

  assign done = busy && (cnt == '0);

  // R4
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  // R4
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

  // R4
  store_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> cells[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int WR_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              store_en_n,
  input  logic              strobe_n,
  input  logic              vpp_hi,
  input  logic [3:0]        ctl,
  input  logic [7:0]        addr_lo,
  input  logic [ADDR_W-9:0] addr_hi,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              ready
);
  otp_op_e           op, p_op;
  logic              wr_req, accept, busy, done, we;
  logic [ADDR_W-1:0] addr, p_addr;
  logic [7:0]        p_data, cell_q, rd_val;
  logic [2:0]        lock_q;
  logic              verify_ok, poll_hit, rd_grant;

  assign addr = {addr_hi, addr_lo};

  otp_mode_decode u_dec (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .store_en_n(store_en_n),
    .strobe_n(strobe_n), .vpp_hi(vpp_hi), .ctl(ctl), .op(op), .wr_req(wr_req)
  );

  assign accept = wr_req && !busy && !((op == OP_WR_CODE) && lock_q[0]);

  otp_write_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(accept), .busy(busy), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_op   <= OP_NONE;
      p_addr <= '0;
      p_data <= '0;
      lock_q <= '0;
    end else begin
      if (accept) begin
        p_op   <= op;
        p_addr <= addr;
        p_data <= din;
      end
      if (done) begin
        case (p_op)
          OP_WR_LK1: lock_q[0] <= 1'b1;
          OP_WR_LK2: lock_q[1] <= 1'b1;
          OP_WR_LK3: lock_q[2] <= 1'b1;
          default:   ;
        endcase
      end
    end
  end

  assign we = done && (p_op == OP_WR_CODE);

  otp_cell_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .we(we), .waddr(p_addr), .wdata(p_data),
    .raddr(addr), .rdata(cell_q)
  );

  assign verify_ok = !lock_q[0] && !lock_q[1];
  assign poll_hit  = busy && (p_op == OP_WR_CODE) && (p_addr == addr);

  always_comb begin
    rd_grant = 1'b0;
    rd_val   = 8'h00;
    if (op == OP_RD_SIG) begin
      rd_grant = 1'b1;
      rd_val   = sig_lookup(16'(addr));
    end else if (op == OP_RD_CODE && verify_ok) begin
      rd_grant = 1'b1;
      rd_val   = poll_hit ? {~p_data[7], p_data[6:0]} : cell_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= 8'h00;
      dout_en <= 1'b0;
    end else begin
      dout    <= rd_val;
      dout_en <= rd_grant;
    end
  end

  assign ready = !busy;

  // R9
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && op == OP_WR_CODE && lock_q[0] && !busy) |=> ready);
  // R10
  verify_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD_CODE && (lock_q[0] || lock_q[1])) |=> !dout_en);
  // R8
  sig_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD_SIG && addr == ADDR_W'('h30)) |=> (dout_en && dout == 8'h1E));
  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_RD_CODE && op != OP_RD_SIG) |=> (!dout_en && dout == 8'h00));
  // R6
  poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RD_CODE && verify_ok && busy && p_op == OP_WR_CODE && addr == p_addr)
      |=> dout[7] != $past(p_data[7]));
endmodule

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;
  localparam int WC = 20;
  localparam logic [3:0] K_WR = 4'b1110, K_L1 = 4'b1111, K_L2 = 4'b0011,
                         K_L3 = 4'b0101, K_RD = 4'b1100, K_SG = 4'b0000,
                         K_NO = 4'b1001;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, prog, store_n, strobe_n, vpp;
  logic [3:0] ctl;
  logic [7:0] alo, din, dout;
  logic [3:0] ahi;
  logic dout_en, ready;

  otp_prog_seq #(.ADDR_W(12), .WR_CYCLES(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog), .store_en_n(store_n),
    .strobe_n(strobe_n), .vpp_hi(vpp), .ctl(ctl), .addr_lo(alo), .addr_hi(ahi),
    .din(din), .dout(dout), .dout_en(dout_en), .ready(ready)
  );

  int vectors = 0, errors = 0;
  string cur_req = "R1";

  // behavioural reference
  logic [7:0] m_mem [0:4095];
  logic [2:0] m_lock;
  logic m_busy, m_sprev, m_en;
  int m_cnt, m_pk, wk, rk;
  logic [11:0] m_pa, a;
  logic [7:0] m_pd, m_dout;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4096; i++) m_mem[i] = 8'hFF;
      m_lock = 3'b000; m_busy = 1'b0; m_cnt = 0; m_pk = -1; m_sprev = 1'b1;
      m_en = 1'b0; m_dout = 8'h00; m_pa = '0; m_pd = '0;
    end else begin
      a = {ahi, alo};
      wk = -1; rk = -1;
      if (prog && !store_n && vpp) begin
        if (ctl == K_WR) wk = 0;
        else if (ctl == K_L1) wk = 1;
        else if (ctl == K_L2) wk = 2;
        else if (ctl == K_L3) wk = 3;
      end
      if (prog && !store_n && !vpp && strobe_n) begin
        if (ctl == K_RD) rk = 0;
        else if (ctl == K_SG) rk = 1;
      end
      m_en = 1'b0; m_dout = 8'h00;
      if (rk == 1) begin
        m_en = 1'b1;
        m_dout = (a == 12'h030) ? 8'h1E : (a == 12'h031) ? 8'h87 :
                 (a == 12'h032) ? 8'h03 : 8'h00;
      end else if (rk == 0 && m_lock[1:0] == 2'b00) begin
        m_en = 1'b1;
        m_dout = (m_busy && m_pk == 0 && m_pa == a) ? {~m_pd[7], m_pd[6:0]} : m_mem[a];
      end
      if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 1'b0;
          if (m_pk == 0) m_mem[m_pa] = m_pd;
          else m_lock[m_pk-1] = 1'b1;
        end else m_cnt--;
      end else if (strobe_n && !m_sprev && wk >= 0 && !(wk == 0 && m_lock[0])) begin
        m_busy = 1'b1; m_cnt = WC - 1; m_pk = wk; m_pa = a; m_pd = din;
      end
      m_sprev = strobe_n;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (ready !== !m_busy || dout_en !== m_en || dout !== m_dout) begin
        errors++;
        $display("FAIL %s: ready/en/dout got %b/%b/%h expected %b/%b/%h",
                 cur_req, ready, dout_en, dout, !m_busy, m_en, m_dout);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
  endtask

  task automatic pgm(input logic [3:0] c, input logic [11:0] ad, input logic [7:0] d);
    ctl = c; {ahi, alo} = ad; din = d; vpp = 1'b1; strobe_n = 1'b1;
    @(negedge clk); strobe_n = 1'b0;
    @(negedge clk); strobe_n = 1'b1;
    @(negedge clk); vpp = 1'b0; ctl = K_NO;
  endtask

  task automatic rd(input logic [3:0] c, input logic [11:0] ad,
                    output logic [7:0] q, output logic en);
    ctl = c; {ahi, alo} = ad; vpp = 1'b0;
    @(negedge clk); q = dout; en = dout_en;
    ctl = K_NO;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic en;
    int n;
    rst_n = 1'b0; prog = 1'b1; store_n = 1'b0; strobe_n = 1'b1; vpp = 1'b0;
    ctl = K_NO; alo = '0; ahi = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 ready", {7'b0, ready}, 8'h01);
    chk("R1 dout_en", {7'b0, dout_en}, 8'h00);
    rd(K_RD, 12'h000, q, en);
    chk("R1 erased", q, 8'hFF);
    chk("R7 read enable", {7'b0, en}, 8'h01);

    cur_req = "R8";
    rd(K_SG, 12'h030, q, en); chk("R8 sig 030", q, 8'h1E);
    rd(K_SG, 12'h031, q, en); chk("R8 sig 031", q, 8'h87);
    rd(K_SG, 12'h032, q, en); chk("R8 sig 032", q, 8'h03);
    rd(K_SG, 12'h033, q, en); chk("R8 sig other", q, 8'h00);

    cur_req = "R3";
    pgm(K_WR, 12'h123, 8'h5A);
    chk("R4 busy after strobe", {7'b0, ready}, 8'h00);
    cur_req = "R6";
    rd(K_RD, 12'h123, q, en); chk("R6 poll inverted", q, 8'hDA);
    rd(K_RD, 12'h124, q, en); chk("R6 other addr", q, 8'hFF);
    cur_req = "R5";
    pgm(K_WR, 12'h200, 8'h11);
    wait_ready();
    rd(K_RD, 12'h200, q, en); chk("R5 dropped write", q, 8'hFF);
    cur_req = "R4";
    rd(K_RD, 12'h123, q, en); chk("R4 committed", q, 8'h5A);

    cur_req = "R3";
    pgm(K_WR, 12'hFFF, 8'h3C);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
    chk("R4 busy length", 8'(n), 8'(WC));
    rd(K_RD, 12'hFFF, q, en); chk("R3 top address", q, 8'h3C);
    rd(K_RD, 12'h0FF, q, en); chk("R3 no alias", q, 8'hFF);

    cur_req = "R7";
    prog = 1'b0;
    rd(K_RD, 12'h123, q, en); chk("R7 idle quiet", {7'b0, en}, 8'h00);
    prog = 1'b1;
    cur_req = "R2";
    store_n = 1'b1;
    rd(K_RD, 12'h123, q, en); chk("R2 store_en_n high", {7'b0, en}, 8'h00);
    store_n = 1'b0;
    ctl = K_RD; vpp = 1'b1; @(negedge clk);
    chk("R2 vpp blocks read", {7'b0, dout_en}, 8'h00);
    vpp = 1'b0; ctl = K_NO;

    cur_req = "R10";
    pgm(K_L1, 12'h000, 8'h00);
    chk("R10 lock busy", {7'b0, ready}, 8'h00);
    wait_ready();
    rd(K_RD, 12'h123, q, en); chk("R10 verify denied", {7'b0, en}, 8'h00);
    rd(K_SG, 12'h031, q, en); chk("R10 sig still served", q, 8'h87);
    cur_req = "R9";
    pgm(K_WR, 12'h123, 8'h00);
    chk("R9 locked write ignored", {7'b0, ready}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R9 ready stays high", {7'b0, ready}, 8'h01);
    cur_req = "R10";
    pgm(K_L2, 12'h000, 8'h00);
    wait_ready();
    rd(K_SG, 12'h032, q, en); chk("R10 sig after lock2", q, 8'h03);
    pgm(K_L3, 12'h000, 8'h00);
    wait_ready();
    rd(K_RD, 12'h000, q, en); chk("R10 denied after lock3", {7'b0, en}, 8'h00);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule